// File: doc/BRIEF.md
# Three-Address Load/Store Processor Core

A small single-issue processor. It steps through a fixed program held in an external instruction memory. The program counter is the fetch address, and the instruction word comes back in the same cycle. There are four 32-bit registers. The register file has two read ports and one write port. The ALU can only add or multiply. Data memory is reached through two independent ports: a load port (address out, data back one cycle later) and a store port (address, data and enable, all out together).

Every instruction names two source registers (A, B) and a destination register (C). Load-immediate, load, add and multiply write C. Store and the non-writing opcodes leave the register file alone. The core has no branches. It runs in order from address 0 until it meets the halt opcode, then holds its state until the next reset.

Top module: `ldst_core`

## Requirements
- R1: While reset is low and right after it is released, `pc_o` is 0, `halted_o` is 0 and all registers hold 0.
- R2: Instruction word format: opcode in bits [24:22], A in [21:20], B in [19:18], C in [17:16], immediate/address in [15:0]. Opcode 1 (load immediate) writes the zero-extended immediate into register C in one cycle.
- R3: Opcode 2 (load) asserts `ld_en_o` with `ld_addr_o` equal to the immediate for one cycle. It then writes the `ld_data_i` value from the following cycle into C. A load takes two cycles, and no memory request is issued in its second cycle.
- R4: Opcode 3 (store) asserts `st_en_o` for one cycle, with `st_addr_o` equal to the immediate and `st_data_o` equal to register A. It does not write the register file.
- R5: Opcode 4 (add) writes A+B modulo 2^32 into C.
- R6: Opcode 5 (multiply) writes the low 32 bits of A*B into C.
- R7: Every instruction except load takes one cycle and advances `pc_o` by one. `ld_en_o` and `st_en_o` are never high together.
- R8: Opcode 7 (halt) raises `halted_o` after one cycle. From then on `pc_o` is frozen and no load or store is issued.
- R9: Opcodes 0 and 6 write no register and issue no memory access. They advance `pc_o` by one.
- R10: The six-instruction sequence R0=M[100], R1=M[101], R2=42, R2=R1*R2, R0=R2+R0, M[100]=R0 leaves M[100] equal to its old value plus 42 times M[101], modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pc_o | output | 8 | Program counter / instruction fetch address |
| instr_i | input | 25 | Instruction word at `pc_o` |
| ld_en_o | output | 1 | Load request |
| ld_addr_o | output | 16 | Load address |
| ld_data_i | input | 32 | Load data, valid the cycle after the request |
| st_en_o | output | 1 | Store strobe |
| st_addr_o | output | 16 | Store address |
| st_data_o | output | 32 | Store data |
| halted_o | output | 1 | Core has executed halt |

## Verification
On every cycle the assertions check the sequencing rules that can be seen at the ports: load and store never overlap, a load request is followed by a quiet cycle with the PC held, single-cycle instructions advance the PC by one, and once halted the core stays frozen and issues no memory traffic. Data results can only be shown by the bench's scenarios. These include the value written by each opcode, zero extension of immediates, add and multiply wrap-around, stores and unused opcodes leaving registers alone, and the end-to-end memory update of the multiply-accumulate program. Each scenario also checks the total cycle count, which confirms that a load costs two cycles.

// File: rtl/ldst_pkg.sv
package ldst_pkg;

  typedef enum logic [2:0] {
    OP_NOP0 = 3'd0,
    OP_LDI  = 3'd1,
    OP_LD   = 3'd2,
    OP_ST   = 3'd3,
    OP_ADD  = 3'd4,
    OP_MUL  = 3'd5,
    OP_NOP6 = 3'd6,
    OP_HALT = 3'd7
  } opcode_e;

  typedef enum logic [1:0] {
    WS_IMM = 2'd0,
    WS_ALU = 2'd1,
    WS_MEM = 2'd2
  } wsel_e;

  typedef enum logic {
    ALU_ADD = 1'b0,
    ALU_MUL = 1'b1
  } alu_op_e;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_LDW  = 2'd1,
    ST_HALT = 2'd2
  } core_state_e;

  typedef struct packed {
    logic    rf_we;
    wsel_e   wsel;
    alu_op_e alu_op;
    logic    ld_en;
    logic    st_en;
    logic    halt;
  } ctl_t;

endpackage

// File: rtl/ldst_decode.sv
module ldst_decode
  import ldst_pkg::*;
(
  input  logic [2:0] opcode_i,
  input  logic       issue_i,
  output ctl_t       ctl_o
);

  always_comb begin
    ctl_o = '{rf_we: 1'b0, wsel: WS_ALU, alu_op: ALU_ADD,
              ld_en: 1'b0, st_en: 1'b0, halt: 1'b0};
    if (issue_i) begin
      unique case (opcode_e'(opcode_i))
        OP_LDI:  begin ctl_o.rf_we = 1'b1; ctl_o.wsel = WS_IMM; end
        OP_LD:   ctl_o.ld_en = 1'b1;
        OP_ST:   ctl_o.st_en = 1'b1;
        OP_ADD:  begin ctl_o.rf_we = 1'b1; ctl_o.alu_op = ALU_ADD; end
        OP_MUL:  begin ctl_o.rf_we = 1'b1; ctl_o.alu_op = ALU_MUL; end
        OP_HALT: ctl_o.halt = 1'b1;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/ldst_regfile.sv
module ldst_regfile #(
  parameter int DATA_W = 32,
  parameter int REG_N  = 4,
  localparam int AW    = $clog2(REG_N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     ra_addr_i,
  input  logic [AW-1:0]     rb_addr_i,
  output logic [DATA_W-1:0] ra_data_o,
  output logic [DATA_W-1:0] rb_data_o,
  input  logic              we_i,
  input  logic [AW-1:0]     w_addr_i,
  input  logic [DATA_W-1:0] w_data_i
);

  logic [DATA_W-1:0] regs_q [REG_N];

  for (genvar g = 0; g < REG_N; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        regs_q[g] <= '0;
      else if (we_i && (w_addr_i == g))   regs_q[g] <= w_data_i;
    end
  end

  assign ra_data_o = regs_q[ra_addr_i];
  assign rb_data_o = regs_q[rb_addr_i];

endmodule

// File: rtl/ldst_alu.sv
module ldst_alu
  import ldst_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  alu_op_e           op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] y_o
);

  logic [DATA_W-1:0] sum, prod;

  assign sum  = a_i + b_i;
  assign prod = a_i * b_i;  // low half only, wraps
  assign y_o  = (op_i == ALU_MUL) ? prod : sum;

endmodule

// File: rtl/ldst_core.sv
module ldst_core
  import ldst_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REG_N  = 4,
  parameter int IMM_W  = 16,
  parameter int PC_W   = 8,
  localparam int RAW     = $clog2(REG_N),
  localparam int OP_W    = 3,
  localparam int INSTR_W = OP_W + 3 * RAW + IMM_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  output logic [PC_W-1:0]    pc_o,
  input  logic [INSTR_W-1:0] instr_i,
  output logic               ld_en_o,
  output logic [IMM_W-1:0]   ld_addr_o,
  input  logic [DATA_W-1:0]  ld_data_i,
  output logic               st_en_o,
  output logic [IMM_W-1:0]   st_addr_o,
  output logic [DATA_W-1:0]  st_data_o,
  output logic               halted_o
);

  // field slicing
  logic [OP_W-1:0]  f_op;
  logic [RAW-1:0]   f_a, f_b, f_c;
  logic [IMM_W-1:0] f_imm;
  assign {f_op, f_a, f_b, f_c, f_imm} = instr_i;

  core_state_e state_q, state_d;
  logic [PC_W-1:0] pc_q, pc_d;
  logic [RAW-1:0]  ld_dst_q;

  ctl_t ctl;
  ldst_decode u_dec (
    .opcode_i (f_op),
    .issue_i  (state_q == ST_RUN),
    .ctl_o    (ctl)
  );

  logic [DATA_W-1:0] ra_data, rb_data, alu_y, imm_ext;
  logic              rf_we;
  logic [RAW-1:0]    rf_waddr;
  logic [DATA_W-1:0] rf_wdata;

  assign imm_ext = {{(DATA_W-IMM_W){1'b0}}, f_imm};

  ldst_alu #(.DATA_W(DATA_W)) u_alu (
    .op_i (ctl.alu_op),
    .a_i  (ra_data),
    .b_i  (rb_data),
    .y_o  (alu_y)
  );

  always_comb begin
    rf_we    = ctl.rf_we;
    rf_waddr = f_c;
    rf_wdata = (ctl.wsel == WS_IMM) ? imm_ext : alu_y;
    if (state_q == ST_LDW) begin
      rf_we    = 1'b1;
      rf_waddr = ld_dst_q;
      rf_wdata = ld_data_i;
    end
  end

  ldst_regfile #(.DATA_W(DATA_W), .REG_N(REG_N)) u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ra_addr_i (f_a),
    .rb_addr_i (f_b),
    .ra_data_o (ra_data),
    .rb_data_o (rb_data),
    .we_i      (rf_we),
    .w_addr_i  (rf_waddr),
    .w_data_i  (rf_wdata)
  );

  always_comb begin
    state_d = state_q;
    pc_d    = pc_q;
    unique case (state_q)
      ST_RUN: begin
        if (ctl.halt)       state_d = ST_HALT;
        else if (ctl.ld_en) state_d = ST_LDW;
        else                pc_d    = pc_q + 1'b1;
      end
      ST_LDW: begin
        state_d = ST_RUN;
        pc_d    = pc_q + 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_RUN;
      pc_q     <= '0;
      ld_dst_q <= '0;
    end else begin
      state_q <= state_d;
      pc_q    <= pc_d;
      if (ctl.ld_en) ld_dst_q <= f_c;
    end
  end

  assign pc_o      = pc_q;
  assign ld_en_o   = ctl.ld_en;
  assign ld_addr_o = f_imm;
  assign st_en_o   = ctl.st_en;
  assign st_addr_o = f_imm;
  assign st_data_o = ra_data;
  assign halted_o  = (state_q == ST_HALT);

endmodule

// File: rtl/ldst_core_chk.sv
module ldst_core_chk #(
  parameter int PC_W = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [PC_W-1:0] pc_o,
  input logic            ld_en_o,
  input logic            st_en_o,
  input logic            halted_o
);

  assert_no_ld_st_overlap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ld_en_o && st_en_o));

  assert_load_wait_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_en_o |=> (!ld_en_o && !st_en_o && $stable(pc_o) && !halted_o));

  assert_store_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_en_o |=> (pc_o == $past(pc_o) + 1'b1));

  assert_halt_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> (halted_o && $stable(pc_o)));

  assert_halt_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |-> (!ld_en_o && !st_en_o));

endmodule

bind ldst_core ldst_core_chk #(.PC_W(PC_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .pc_o     (pc_o),
  .ld_en_o  (ld_en_o),
  .st_en_o  (st_en_o),
  .halted_o (halted_o)
);

// File: tb/tb_ldst_core.sv
`timescale 1ns/1ps
module tb_ldst_core;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  pc;
  logic [24:0] instr;
  logic        ld_en, st_en, halted;
  logic [15:0] ld_addr, st_addr;
  logic [31:0] ld_data, st_data;

  logic [24:0] imem [32];
  logic [31:0] dmem [256];

  int n_tests = 0;
  int n_fail  = 0;
  int n_stores = 0;

  always #2.5 clk = ~clk;

  assign instr = imem[pc[4:0]];

  always @(posedge clk) begin
    if (ld_en) ld_data <= dmem[ld_addr[7:0]];
    if (st_en) begin
      dmem[st_addr[7:0]] <= st_data;
      n_stores <= n_stores + 1;
    end
  end

  ldst_core dut (
    .clk_i(clk), .rst_ni(rst_n), .pc_o(pc), .instr_i(instr),
    .ld_en_o(ld_en), .ld_addr_o(ld_addr), .ld_data_i(ld_data),
    .st_en_o(st_en), .st_addr_o(st_addr), .st_data_o(st_data),
    .halted_o(halted)
  );

  function automatic logic [24:0] enc(input int op, input int a, input int b,
                                      input int c, input int imm);
    return {op[2:0], a[1:0], b[1:0], c[1:0], imm[15:0]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 32; i++) imem[i] = enc(7, 0, 0, 0, 0);
    for (int i = 0; i < 256; i++) dmem[i] = 32'hDEAD_0000 + i;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // returns cycles from reset release until halted_o is seen
  task automatic run(output int cycles);
    cycles = 0;
    while (!halted && cycles < 100) begin
      @(posedge clk);
      cycles++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    clear_mem();
    imem[0] = enc(1, 0, 0, 0, 1);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 pc in reset", 32'(pc), 0);
    check("R1 halted in reset", 32'(halted), 0);
    check("R1 no mem access in reset", 32'({ld_en, st_en}), 0);
    rst_n = 1'b1;
  endtask

  task automatic t_ldi();
    int cyc;
    clear_mem();
    imem[0] = enc(1, 0, 0, 0, 16'hFFFF);
    imem[1] = enc(1, 0, 0, 1, 5);
    imem[2] = enc(3, 0, 0, 0, 10);
    imem[3] = enc(3, 1, 0, 0, 11);
    imem[4] = enc(3, 2, 0, 0, 12);
    do_reset();
    check("R1 pc after reset", 32'(pc), 0);
    run(cyc);
    check("R2 ldi zero-extended", dmem[10], 32'h0000_FFFF);
    check("R2 ldi small", dmem[11], 5);
    check("R1 reg reset to zero", dmem[12], 0);
    check("R7 one cycle per op", cyc, 6);
    check("R8 pc frozen at halt", 32'(pc), 5);
  endtask

  task automatic t_arith();
    int cyc;
    clear_mem();
    dmem[20] = 32'hFFFF_FFFF;
    dmem[23] = 32'h4000_0001;
    imem[0] = enc(2, 0, 0, 0, 20);
    imem[1] = enc(1, 0, 0, 1, 1);
    imem[2] = enc(4, 0, 1, 2, 0);
    imem[3] = enc(3, 2, 0, 0, 21);
    imem[4] = enc(1, 0, 0, 1, 3);
    imem[5] = enc(2, 0, 0, 3, 23);
    imem[6] = enc(5, 3, 1, 2, 0);
    imem[7] = enc(3, 2, 0, 0, 24);
    do_reset();
    run(cyc);
    check("R5 add wraps", dmem[21], 0);
    check("R6 mul low half", dmem[24], 32'hC000_0003);
    check("R3 load costs two cycles", cyc, 11);
  endtask

  task automatic t_nowrite();
    int cyc;
    clear_mem();
    imem[0] = enc(1, 0, 0, 0, 7);
    imem[1] = enc(1, 0, 0, 1, 9);
    imem[2] = enc(3, 1, 0, 0, 30);
    imem[3] = enc(0, 0, 0, 0, 99);
    imem[4] = enc(6, 1, 1, 0, 99);
    imem[5] = enc(3, 0, 0, 0, 31);
    do_reset();
    run(cyc);
    check("R4 store data from A", dmem[30], 9);
    check("R4 R9 store and spare ops leave C", dmem[31], 7);
    check("R9 spare ops one cycle", cyc, 7);
    check("R9 no stray store", dmem[99], 32'hDEAD_0063);
  endtask

  task automatic t_program(input logic [31:0] m0, input logic [31:0] m1);
    int cyc;
    clear_mem();
    dmem[100] = m0;
    dmem[101] = m1;
    imem[0] = enc(2, 0, 0, 0, 100);
    imem[1] = enc(2, 0, 0, 1, 101);
    imem[2] = enc(1, 0, 0, 2, 42);
    imem[3] = enc(5, 1, 2, 2, 0);
    imem[4] = enc(4, 2, 0, 0, 0);
    imem[5] = enc(3, 0, 0, 0, 100);
    do_reset();
    run(cyc);
    check("R10 mem update", dmem[100], m0 + 32'd42 * m1);
    check("R10 cycle count", cyc, 9);
  endtask

  task automatic t_halt();
    int cyc, s0;
    logic [7:0] pc0;
    clear_mem();
    imem[0] = enc(1, 0, 0, 0, 5);
    imem[1] = enc(7, 0, 0, 0, 0);
    imem[2] = enc(3, 0, 0, 0, 40);
    do_reset();
    run(cyc);
    check("R8 halted after one cycle", cyc, 2);
    pc0 = pc;
    s0 = n_stores;
    repeat (8) @(negedge clk);
    check("R8 pc frozen", 32'(pc), 32'(pc0));
    check("R8 halted stays", 32'(halted), 1);
    check("R8 no store after halt", n_stores - s0, 0);
    check("R8 mem untouched", dmem[40], 32'hDEAD_0028);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_ldi();
    t_arith();
    t_nowrite();
    t_program(32'd1000, 32'd3);
    t_program(32'hFFFF_FFF0, 32'h1000_0000);
    t_halt();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule